// File: doc/BRIEF.md
# Temperature Code Calibration Converter

This block converts in both directions between a temperature in whole degrees Celsius and the raw 8-bit code a thermal sensor produces. The linear mapping comes from stored trim values and a mode select. The modes are a fixed offset, a one-point trim, and a two-point trim that interpolates between the 25 °C and 85 °C calibration codes. The two-point mapping needs a true division, which a sequential restoring divider performs. Every other mapping finishes in a single cycle.

Trim values arrive on input ports and are captured on a load strobe. At capture the first trim is checked: a value outside 40..100, or a non-zero second trim, makes the block store a default value from its own port in place of the first trim. An optional legacy check rejects operands outside the calibrated window. Every request returns one done pulse, carrying either a result or an error flag.

Top module: `tcc_conv`

## Requirements
- R1: With cal_mode 0 or 3 (fixed offset), direction 0 (temperature to code) returns operand + 50 and direction 1 (code to temperature) returns operand − 50.
- R2: With cal_mode 1 (one point), direction 0 returns operand + T1 − 25 and direction 1 returns operand − T1 + 25, where T1 is the stored first trim.
- R3: With cal_mode 2 (two point), direction 0 returns (operand − 25)·(T2 − T1)/60 + T1, with the quotient truncated toward zero.
- R4: With cal_mode 2, direction 1 returns (operand − T1)·60/(T2 − T1) + 25, with the quotient truncated toward zero.
- R5: With cal_mode 2 and direction 1, T2 equal to T1 raises err with result 0 and performs no division.
- R6: When range_chk is 1, a direction-0 operand outside 25..125 or a direction-1 operand outside 75..175 raises err with result 0. The bounds themselves are accepted.
- R7: On trim_load, T2 takes trim2_in. T1 takes trim1_in when that value lies in 40..100 and trim2_in is 0; otherwise T1 takes fuse_dflt.
- R8: A computed value below 0 or above 255 raises err. Whenever err is 1, result is 0.
- R9: done is high for one cycle per accepted request. In cal_mode 0, 1 and 3, and for any request rejected before division, done comes in the cycle after acceptance and busy stays low. In cal_mode 2 without early rejection, busy is high from the cycle after acceptance until done, and busy is low while done is high.
- R10: A request while busy is high is ignored: it produces no done pulse and leaves result and err unchanged. result and err change only in cycles where done is high.
- R11: After reset, done, busy, err and result are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trim_load | input | 1 | Capture the trim ports into the trim store |
| trim1_in | input | 8 | First trim code (25 °C point) |
| trim2_in | input | 8 | Second trim code (85 °C point) |
| fuse_dflt | input | 8 | Substitute first trim used when validation fails |
| cal_mode | input | 2 | 0 fixed offset, 1 one point, 2 two point, 3 fixed offset |
| range_chk | input | 1 | Enable the legacy operand window check |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_dir | input | 1 | 0 temperature to code, 1 code to temperature |
| req_val | input | 8 | Operand |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag for the completed request |
| result | output | 8 | Converted value, 0 on error |

## Verification
The assertions assume that req_valid is sampled only on clock edges and that trim_load, cal_mode and range_chk change only between requests. A trim change during a division would leave the addend and the divisor inconsistent. The bench keeps to these assumptions: it drives every input on the falling edge and reloads trims only while the block is idle. It drives a second request only in the deliberate busy-overlap case. The random mix covers all four mode codes, both directions, the full operand range and random trims, so the fallback and the error paths are exercised as well as the good results.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   typedef enum logic [1:0] {
      CAL_FIXED = 2'd0,
      CAL_ONE   = 2'd1,
      CAL_TWO   = 2'd2,
      CAL_ALT   = 2'd3
   } cal_mode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_DIV  = 1'b1
   } conv_state_e;
endpackage

// File: rtl/tcc_trim.sv
module tcc_trim #(
   parameter int DW     = 8,
   parameter int EF_MIN = 40,
   parameter int EF_MAX = 100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] trim1_in,
   input  logic [DW-1:0] trim2_in,
   input  logic [DW-1:0] fuse_in,
   output logic [DW-1:0] trim1_q,
   output logic [DW-1:0] trim2_q
);
   localparam logic [DW-1:0] LO = DW'(EF_MIN);
   localparam logic [DW-1:0] HI = DW'(EF_MAX);

   logic t1_bad;

   always_comb begin
      t1_bad = (trim1_in < LO) || (trim1_in > HI) || (trim2_in != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim1_q <= '0;
         trim2_q <= '0;
      end else if (load) begin
         trim1_q <= t1_bad ? fuse_in : trim1_in;
         trim2_q <= trim2_in;
      end
   end
endmodule

// File: rtl/tcc_prep.sv
module tcc_prep
   import tcc_pkg::*;
#(
   parameter int DW        = 8,
   parameter int SW        = 18,
   parameter int OFFSET    = 50,
   parameter int REF_LO    = 25,
   parameter int REF_HI    = 85,
   parameter int LO_T      = 25,
   parameter int HI_T      = 125,
   parameter int LO_C      = 75,
   parameter int HI_C      = 175,
   parameter bit LEGACY_EN = 1'b1
) (
   input  logic                 dir,
   input  logic [DW-1:0]        val,
   input  cal_mode_e            mode,
   input  logic [DW-1:0]        t1,
   input  logic [DW-1:0]        t2,
   input  logic                 range_chk,
   output logic                 use_div,
   output logic                 pre_err,
   output logic signed [SW-1:0] num,
   output logic signed [SW-1:0] den,
   output logic signed [SW-1:0] addend,
   output logic signed [SW-1:0] direct
);
   localparam logic signed [SW-1:0] K_OFF  = SW'(OFFSET);
   localparam logic signed [SW-1:0] K_REF  = SW'(REF_LO);
   localparam logic signed [SW-1:0] K_SPAN = SW'(REF_HI - REF_LO);

   logic signed [SW-1:0] v_s, t1_s, t2_s, dt_s;
   logic                 range_fail;

   always_comb begin
      v_s  = {{(SW-DW){1'b0}}, val};
      t1_s = {{(SW-DW){1'b0}}, t1};
      t2_s = {{(SW-DW){1'b0}}, t2};
      dt_s = t2_s - t1_s;
   end

   generate
      if (LEGACY_EN) begin : g_window
         localparam logic [DW-1:0] WLT = DW'(LO_T);
         localparam logic [DW-1:0] WHT = DW'(HI_T);
         localparam logic [DW-1:0] WLC = DW'(LO_C);
         localparam logic [DW-1:0] WHC = DW'(HI_C);
         always_comb begin
            if (dir) range_fail = range_chk && ((val < WLC) || (val > WHC));
            else     range_fail = range_chk && ((val < WLT) || (val > WHT));
         end
      end else begin : g_nowindow
         always_comb range_fail = 1'b0;
      end
   endgenerate

   always_comb begin
      use_div = 1'b0;
      num     = '0;
      den     = K_SPAN;
      addend  = '0;
      direct  = '0;
      unique case (mode)
         CAL_ONE: begin
            direct = dir ? (v_s - t1_s + K_REF) : (v_s + t1_s - K_REF);
         end
         CAL_TWO: begin
            use_div = 1'b1;
            if (dir) begin
               num    = (v_s - t1_s) * K_SPAN;
               den    = dt_s;
               addend = K_REF;
            end else begin
               num    = (v_s - K_REF) * dt_s;
               den    = K_SPAN;
               addend = t1_s;
            end
         end
         default: begin
            direct = dir ? (v_s - K_OFF) : (v_s + K_OFF);
         end
      endcase
      pre_err = range_fail || (use_div && (den == '0));
   end
endmodule

// File: rtl/tcc_sdiv.sv
module tcc_sdiv #(
   parameter int SW = 18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic signed [SW-1:0] num,
   input  logic signed [SW-1:0] den,
   output logic                 qdone,
   output logic signed [SW-1:0] quot
);
   localparam int CW = $clog2(SW + 1);

   logic [SW-1:0] dq, d_mag, n_mag, d_in;
   logic [SW:0]   rm, shifted, d_ext;
   logic [CW-1:0] cnt;
   logic          neg, ge;

   always_comb begin
      n_mag   = num[SW-1] ? (-num) : num;
      d_in    = den[SW-1] ? (-den) : den;
      d_ext   = {1'b0, d_mag};
      shifted = {rm[SW-1:0], dq[SW-1]};
      ge      = (shifted >= d_ext);
      quot    = neg ? (-dq) : dq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq    <= '0;
         d_mag <= '0;
         rm    <= '0;
         cnt   <= '0;
         neg   <= 1'b0;
         qdone <= 1'b0;
      end else begin
         qdone <= 1'b0;
         if (start) begin
            dq    <= n_mag;
            d_mag <= d_in;
            rm    <= '0;
            cnt   <= CW'(SW);
            neg   <= num[SW-1] ^ den[SW-1];
         end else if (cnt != '0) begin
            rm    <= ge ? (shifted - d_ext) : shifted;
            dq    <= {dq[SW-2:0], ge};
            cnt   <= cnt - 1'b1;
            qdone <= (cnt == CW'(1));
         end
      end
   end
endmodule

// File: rtl/tcc_conv.sv
module tcc_conv
   import tcc_pkg::*;
#(
   parameter int DW        = 8,
   parameter int OFFSET    = 50,
   parameter int REF_LO    = 25,
   parameter int REF_HI    = 85,
   parameter int LO_T      = 25,
   parameter int HI_T      = 125,
   parameter int LO_C      = 75,
   parameter int HI_C      = 175,
   parameter int EF_MIN    = 40,
   parameter int EF_MAX    = 100,
   parameter bit LEGACY_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trim_load,
   input  logic [DW-1:0] trim1_in,
   input  logic [DW-1:0] trim2_in,
   input  logic [DW-1:0] fuse_dflt,
   input  logic [1:0]    cal_mode,
   input  logic          range_chk,
   input  logic          req_valid,
   input  logic          req_dir,
   input  logic [DW-1:0] req_val,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [DW-1:0] result
);
   localparam int SW = 2*DW + 2;
   localparam logic signed [SW-1:0] K_MAX = SW'((1 << DW) - 1);

   generate
      if (DW < 4)             begin : g_bad_dw   $error("DW too small");          end
      if (REF_HI <= REF_LO)   begin : g_bad_ref  $error("bad reference points");  end
      if (LO_T > HI_T)        begin : g_bad_twin $error("bad temperature window"); end
      if (LO_C > HI_C)        begin : g_bad_cwin $error("bad code window");       end
      if (HI_C >= (1 << DW))  begin : g_bad_hic  $error("code window too wide");  end
      if (EF_MIN > EF_MAX)    begin : g_bad_ef   $error("bad trim bounds");       end
   endgenerate

   conv_state_e          st;
   logic [DW-1:0]        t1_q, t2_q;
   logic                 use_div, pre_err, accept, dv_start, dv_done;
   logic signed [SW-1:0] num, den, addend, direct, dv_q, add_q, dv_sum;
   logic                 direct_bad, sum_bad;

   tcc_trim #(.DW(DW), .EF_MIN(EF_MIN), .EF_MAX(EF_MAX)) u_trim (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (trim_load),
      .trim1_in (trim1_in),
      .trim2_in (trim2_in),
      .fuse_in  (fuse_dflt),
      .trim1_q  (t1_q),
      .trim2_q  (t2_q)
   );

   tcc_prep #(
      .DW(DW), .SW(SW), .OFFSET(OFFSET), .REF_LO(REF_LO), .REF_HI(REF_HI),
      .LO_T(LO_T), .HI_T(HI_T), .LO_C(LO_C), .HI_C(HI_C), .LEGACY_EN(LEGACY_EN)
   ) u_prep (
      .dir       (req_dir),
      .val       (req_val),
      .mode      (cal_mode_e'(cal_mode)),
      .t1        (t1_q),
      .t2        (t2_q),
      .range_chk (range_chk),
      .use_div   (use_div),
      .pre_err   (pre_err),
      .num       (num),
      .den       (den),
      .addend    (addend),
      .direct    (direct)
   );

   tcc_sdiv #(.SW(SW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (dv_start),
      .num   (num),
      .den   (den),
      .qdone (dv_done),
      .quot  (dv_q)
   );

   always_comb begin
      accept     = req_valid && (st == ST_IDLE);
      dv_start   = accept && use_div && !pre_err;
      direct_bad = direct[SW-1] || (direct > K_MAX);
      dv_sum     = dv_q + add_q;
      sum_bad    = dv_sum[SW-1] || (dv_sum > K_MAX);
      busy       = (st == ST_DIV);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         add_q  <= '0;
         done   <= 1'b0;
         err    <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  if (pre_err) begin
                     done   <= 1'b1;
                     err    <= 1'b1;
                     result <= '0;
                  end else if (!use_div) begin
                     done   <= 1'b1;
                     err    <= direct_bad;
                     result <= direct_bad ? '0 : direct[DW-1:0];
                  end else begin
                     st    <= ST_DIV;
                     add_q <= addend;
                  end
               end
            end
            ST_DIV: begin
               if (dv_done) begin
                  st     <= ST_IDLE;
                  done   <= 1'b1;
                  err    <= sum_bad;
                  result <= sum_bad ? '0 : dv_sum[DW-1:0];
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tcc_chk.sv
module tcc_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic [DW-1:0] result
);
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9
   busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   // R10
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   // R8
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (result == '0));

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(err)));
endmodule

bind tcc_conv tcc_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .result    (result)
);

// File: tb/sim_tcc_conv.sv
`timescale 1ns/1ps
module sim_tcc_conv;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trim_load = 1'b0;
   logic [7:0] trim1_in = '0, trim2_in = '0, fuse_dflt = '0;
   logic [1:0] cal_mode = '0;
   logic       range_chk = 1'b0;
   logic       req_valid = 1'b0, req_dir = 1'b0;
   logic [7:0] req_val = '0;
   logic       busy, done, err;
   logic [7:0] result;

   int nchk = 0, nerr = 0, cyc = 0;
   int cur_t1 = 0, cur_t2 = 0;

   always #4 clk = ~clk;

   tcc_conv u0 (
      .clk(clk), .rst_n(rst_n), .trim_load(trim_load), .trim1_in(trim1_in),
      .trim2_in(trim2_in), .fuse_dflt(fuse_dflt), .cal_mode(cal_mode),
      .range_chk(range_chk), .req_valid(req_valid), .req_dir(req_dir),
      .req_val(req_val), .busy(busy), .done(done), .err(err), .result(result)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int eff_t1(input int a, input int b, input int f);
      return (a < 40 || a > 100 || b != 0) ? f : a;
   endfunction

   function automatic void model(input int mode, input int dir, input int v,
                                 input int t1, input int t2, input int rc,
                                 output bit e, output int r, output bit dv);
      int res = 0;
      e = 0; dv = 0;
      if (rc != 0 && (dir != 0 ? (v < 75 || v > 175) : (v < 25 || v > 125))) e = 1;
      else if (mode == 1) res = (dir != 0) ? v - t1 + 25 : v + t1 - 25;
      else if (mode == 2) begin
         if (dir != 0 && t2 == t1) e = 1;
         else begin
            dv  = 1;
            res = (dir != 0) ? (v - t1) * 60 / (t2 - t1) + 25
                             : (v - 25) * (t2 - t1) / 60 + t1;
         end
      end else res = (dir != 0) ? v - 50 : v + 50;
      if (!e && (res < 0 || res > 255)) e = 1;
      r = e ? 0 : res;
   endfunction

   task automatic load_trim(input int a, input int b, input int f);
      @(negedge clk);
      trim1_in = 8'(a); trim2_in = 8'(b); fuse_dflt = 8'(f); trim_load = 1'b1;
      @(negedge clk);
      trim_load = 1'b0;
      cur_t1 = eff_t1(a, b, f);
      cur_t2 = b;
   endtask

   task automatic conv(input int mode, input int dir, input int v, input int rc,
                       input string tag);
      bit e, dv, bsy;
      int r, n;
      model(mode, dir, v, cur_t1, cur_t2, rc, e, r, dv);
      cal_mode = 2'(mode); req_dir = dir[0]; req_val = 8'(v); range_chk = rc[0];
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      bsy = busy;
      n = 0;
      while (!done && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk(n < 100, {tag, " timeout"}, n, 0);
      chk(err == e, {tag, " err"}, int'(err), int'(e));
      chk(result == 8'(r), {tag, " result"}, int'(result), r);
      chk(bsy == dv, "R9 busy", int'(bsy), int'(dv));
      @(negedge clk);
      chk(!done, "R9 pulse", int'(done), 0);
   endtask

   initial begin : watchdog
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin : main
      int dn;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!done && !busy && !err && result == 0, "R11", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !busy && !err && result == 0, "R11 after release", int'(result), 0);

      // R7 trim validation and fallback, observed through one-point mode (R2)
      load_trim(39, 0, 60);  conv(1, 0, 50, 0, "R7 low trim");
      load_trim(40, 0, 60);  conv(1, 0, 50, 0, "R7 bound40");
      load_trim(100, 0, 60); conv(1, 0, 50, 0, "R7 bound100");
      load_trim(101, 0, 60); conv(1, 0, 50, 0, "R7 high trim");
      load_trim(70, 5, 60);  conv(1, 0, 50, 0, "R7 trim2 set");
      load_trim(70, 0, 60);  conv(1, 1, 120, 0, "R2 inverse");

      // R1 fixed offset, R8 out of range
      conv(0, 0, 30, 0, "R1 fwd");
      conv(3, 1, 130, 0, "R1 alt mode");
      conv(0, 0, 210, 0, "R8 over");
      conv(0, 1, 40, 0, "R8 under");
      conv(0, 1, 50, 0, "R8 zero edge");
      conv(0, 0, 205, 0, "R8 top edge");

      // R3 / R4 two point with truncation toward zero
      load_trim(77, 80, 50);
      conv(2, 0, 30, 0, "R3 pos");
      conv(2, 0, 20, 0, "R3 neg trunc");
      conv(2, 1, 47, 0, "R4 neg");
      conv(2, 1, 51, 0, "R4 pos");

      // R6 legacy window
      conv(2, 1, 74, 1, "R6 code low");
      conv(2, 1, 75, 1, "R6 code edge");
      conv(1, 0, 126, 1, "R6 temp high");
      conv(1, 0, 125, 1, "R6 temp edge");
      conv(0, 0, 24, 1, "R6 temp low");
      conv(0, 1, 176, 1, "R6 code high");

      // R5 zero divisor
      load_trim(0, 50, 50);
      conv(2, 1, 100, 0, "R5 zero div");
      conv(2, 0, 100, 0, "R5 fwd ok");

      // R10 request while busy ignored
      load_trim(0, 80, 50);
      cal_mode = 2'd2; req_dir = 1'b1; req_val = 8'd51; range_chk = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_dir = 1'b0; req_val = 8'd200;
      @(negedge clk);
      req_valid = 1'b0;
      dn = 0;
      for (int i = 0; i < 40; i++) begin
         if (done) dn++;
         @(negedge clk);
      end
      chk(dn == 1, "R10 done count", dn, 1);
      chk(result == 8'd27 && !err, "R10 result", int'(result), 27);

      // random mix
      for (int i = 0; i < 300; i++) begin
         int m, d, v, rc;
         if (i % 20 == 0)
            load_trim(int'($urandom_range(30, 110)),
                      ($urandom % 3 == 0) ? 0 : int'($urandom_range(0, 255)),
                      int'($urandom_range(40, 100)));
         m  = int'($urandom_range(0, 3));
         d  = int'($urandom_range(0, 1));
         v  = int'($urandom_range(0, 255));
         rc = ($urandom % 4 == 0) ? 1 : 0;
         conv(m, d, v, rc, (m == 2) ? (d != 0 ? "R4 rand" : "R3 rand")
                         : (m == 1) ? "R2 rand" : "R1 rand");
      end

      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule